// File: doc/BRIEF.md
# NAND flash address cycle generator

This block carries out one address-phase instruction for a NAND flash command sequencer. The sequencer hands it an instruction on a valid/ready channel. The block then drives the address bytes onto the 8-bit flash data bus, one byte for each write-enable pulse, and keeps the address-latch-enable strobe high for the whole slot of every byte. Four instruction codes are supported.

- A column address is built from the column index. It is forced to zero when the transfer byte count is zero.
- A page address joins the block index above the page-in-block index.
- A user byte is taken from a 32-bit mailbox through a write pointer. The pointer runs out to zero bytes after the fourth.
- A no-operation instruction lasts as long as one byte slot but drives no strobe.

The instruction channel follows valid/ready rules. The sequencer holds `ins_valid` and `ins_op` until a cycle in which `ins_ready` is also high, and the instruction is accepted on that clock edge. `ins_ready` is high only when the block is idle, so back-pressure lasts for the whole instruction, including the done cycle. All configuration inputs are sampled on the accept edge. The mailbox write pointer is shared with the sequencer's write-status-byte instructions, which advance it through `wrs_adv`. `seq_start` returns the pointer to byte 0 at the start of each instruction sequence.

Top module: `nand_addr_gen`

## Requirements
- R1: `ins_ready` is 1 only while idle; an instruction is accepted on a clock edge where `ins_valid` and `ins_ready` are both 1, and `ins_ready` stays 0 from the next cycle until the cycle after `done`.
- R2: While an address byte is driven, `ale` is 1 in every cycle in which `we_n` is 0, and `bus_data` stays constant across the low phase of the byte.
- R3: A column instruction (`ins_op`=1) sends 1 byte when `cfg_wide_page`=0 and 2 bytes when it is 1.
- R4: The column value is `cfg_col`, except that 0 is sent when `cfg_bcount`=0.
- R5: A page instruction (`ins_op`=2) sends 2, 3 or 4 bytes for `cfg_alen` = 0, 1 or 2; the value 3 also gives 4 bytes.
- R6: The page value is {`cfg_block`, `cfg_page`}, zero-extended. Multi-byte column and page values are sent least significant byte first.
- R7: A user instruction (`ins_op`=3) sends one byte, mailbox byte p, where p is the write pointer and byte 0 is `mbox[7:0]`; the pointer then advances; when p is 4 or more the byte sent is 0x00.
- R8: A `wrs_adv` pulse advances the same write pointer by one, and `seq_start` resets it to 0.
- R9: A no-operation instruction (`ins_op`=0) lasts one byte slot plus the done cycle, with `we_n`=1 and `ale`=0 throughout.
- R10: For each byte, `we_n` is low for `cfg_we_lo`+1 clocks and then high for `cfg_we_hi`+1 clocks.
- R11: `done` is a one-cycle pulse in the cycle after the high phase of the last byte ends, and `ins_ready` returns in the following cycle.
- R12: After reset, `we_n`=1, `ale`=0, `done`=0 and `ins_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Block idle and able to accept an instruction |
| ins_op | input | 2 | 0 no-op, 1 column, 2 page, 3 user byte |
| seq_start | input | 1 | Start of sequence; clears the mailbox write pointer |
| wrs_adv | input | 1 | A write-status-byte instruction consumed one mailbox byte |
| cfg_wide_page | input | 1 | Two-byte column address when 1 |
| cfg_alen | input | 2 | Page address length code |
| cfg_block | input | BLK_W | Block index |
| cfg_page | input | PG_W | Page-in-block index |
| cfg_col | input | COL_W | Column index |
| cfg_bcount | input | BC_W | Transfer byte count |
| mbox | input | 32 | User address mailbox |
| cfg_we_lo | input | TW | Write-enable low time minus one |
| cfg_we_hi | input | TW | Write-enable high time minus one |
| bus_data | output | 8 | Flash data bus |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write enable, active low |
| done | output | 1 | One-cycle instruction completion pulse |

## Verification
The assertions check the properties that hold in every cycle: `ale` covering each write-enable low cycle, a stable bus during a low phase, no-op slots that stay strobe-free, the ready drop after an accept, and the single-cycle done pulse followed by a return to ready. Only the bench scenarios can show that the bytes and their order are correct, which needs sweeps over address length, page-size flag, byte count and the low and high times. The same applies to the mailbox pointer, whose saturation to zero, shared advance through `wrs_adv` and reset by `seq_start` show only over sequences of instructions.

// File: rtl/naddr_pkg.sv
package naddr_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_COL  = 2'd1,
    OP_PAGE = 2'd2,
    OP_USER = 2'd3
  } naddr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_DONE = 2'd3
  } naddr_st_e;
endpackage

// File: rtl/naddr_former.sv
module naddr_former
  import naddr_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int PG_W  = 6,
  parameter int COL_W = 12,
  parameter int BC_W  = 12
) (
  input  logic [1:0]       op,
  input  logic             wide_page,
  input  logic [1:0]       alen,
  input  logic [BLK_W-1:0] block_idx,
  input  logic [PG_W-1:0]  page_idx,
  input  logic [COL_W-1:0] col_idx,
  input  logic [BC_W-1:0]  bcount,
  input  logic [7:0]       user_byte,
  output logic [31:0]      word,
  output logic [2:0]       nbytes
);
  localparam int PA_W = BLK_W + PG_W;

  logic [31:0] page_word;
  logic [31:0] col_word;

  always_comb begin
    page_word = '0;
    page_word[PA_W-1:0] = {block_idx, page_idx};
    col_word = '0;
    if (bcount != '0) col_word[COL_W-1:0] = col_idx;
  end

  always_comb begin
    word   = '0;
    nbytes = 3'd1;
    unique case (naddr_op_e'(op))
      OP_COL: begin
        word   = col_word;
        nbytes = wide_page ? 3'd2 : 3'd1;
      end
      OP_PAGE: begin
        word = page_word;
        unique case (alen)
          2'd0:    nbytes = 3'd2;
          2'd1:    nbytes = 3'd3;
          default: nbytes = 3'd4;
        endcase
      end
      OP_USER: begin
        word   = {24'd0, user_byte};
        nbytes = 3'd1;
      end
      default: begin
        word   = '0;
        nbytes = 3'd1;
      end
    endcase
  end
endmodule

// File: rtl/naddr_mbox_ptr.sv
module naddr_mbox_ptr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        adv_ins,
  input  logic        adv_wrs,
  input  logic [31:0] mbox,
  output logic [7:0]  cur_byte
);
  localparam logic [2:0] PTR_END = 3'd4;

  logic [2:0] ptr;
  logic [2:0] step;
  logic [3:0] sum;

  always_comb begin
    step = {2'b00, adv_ins} + {2'b00, adv_wrs};
    sum  = {1'b0, ptr} + {1'b0, step};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) ptr <= '0;
    else if (sum > {1'b0, PTR_END}) ptr <= PTR_END;
    else ptr <= sum[2:0];
  end

  always_comb begin
    if (ptr[2]) cur_byte = 8'h00;
    else cur_byte = mbox[{ptr[1:0], 3'b000} +: 8];
  end
endmodule

// File: rtl/naddr_strobe_timer.sv
module naddr_strobe_timer
  import naddr_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    nbytes,
  input  logic [TW-1:0] lo_len,
  input  logic [TW-1:0] hi_len,
  output logic          busy,
  output logic          slot,
  output logic          low_phase,
  output logic          step,
  output logic          done
);
  naddr_st_e     st;
  logic [TW-1:0] cnt;
  logic [TW-1:0] lo_q;
  logic [TW-1:0] hi_q;
  logic [2:0]    left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      lo_q <= '0;
      hi_q <= '0;
      left <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st   <= ST_LO;
          cnt  <= '0;
          lo_q <= lo_len;
          hi_q <= hi_len;
          left <= nbytes - 3'd1;
        end
        ST_LO: begin
          if (cnt == lo_q) begin
            st  <= ST_HI;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_HI: begin
          if (cnt == hi_q) begin
            cnt <= '0;
            if (left == 3'd0) st <= ST_DONE;
            else begin
              st   <= ST_LO;
              left <= left - 3'd1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != ST_IDLE);
    slot      = (st == ST_LO) || (st == ST_HI);
    low_phase = (st == ST_LO);
    step      = (st == ST_HI) && (cnt == hi_q) && (left != 3'd0);
    done      = (st == ST_DONE);
  end
endmodule

// File: rtl/nand_addr_gen.sv
module nand_addr_gen
  import naddr_pkg::*;
#(
  parameter int BLK_W = 16,
  parameter int PG_W  = 6,
  parameter int COL_W = 12,
  parameter int BC_W  = 12,
  parameter int TW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  output logic             ins_ready,
  input  logic [1:0]       ins_op,
  input  logic             seq_start,
  input  logic             wrs_adv,
  input  logic             cfg_wide_page,
  input  logic [1:0]       cfg_alen,
  input  logic [BLK_W-1:0] cfg_block,
  input  logic [PG_W-1:0]  cfg_page,
  input  logic [COL_W-1:0] cfg_col,
  input  logic [BC_W-1:0]  cfg_bcount,
  input  logic [31:0]      mbox,
  input  logic [TW-1:0]    cfg_we_lo,
  input  logic [TW-1:0]    cfg_we_hi,
  output logic [7:0]       bus_data,
  output logic             ale,
  output logic             we_n,
  output logic             done
);
  logic        accept;
  logic        busy;
  logic        slot;
  logic        low_phase;
  logic        step;
  logic [7:0]  user_byte;
  logic [31:0] word;
  logic [2:0]  nbytes;
  logic [31:0] sh;
  logic        addr_q;

  assign ins_ready = !busy;
  assign accept    = ins_valid && ins_ready;

  naddr_mbox_ptr u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (seq_start),
    .adv_ins  (accept && (ins_op == OP_USER)),
    .adv_wrs  (wrs_adv),
    .mbox     (mbox),
    .cur_byte (user_byte)
  );

  naddr_former #(
    .BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W), .BC_W(BC_W)
  ) u_form (
    .op        (ins_op),
    .wide_page (cfg_wide_page),
    .alen      (cfg_alen),
    .block_idx (cfg_block),
    .page_idx  (cfg_page),
    .col_idx   (cfg_col),
    .bcount    (cfg_bcount),
    .user_byte (user_byte),
    .word      (word),
    .nbytes    (nbytes)
  );

  naddr_strobe_timer #(.TW(TW)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .nbytes    (nbytes),
    .lo_len    (cfg_we_lo),
    .hi_len    (cfg_we_hi),
    .busy      (busy),
    .slot      (slot),
    .low_phase (low_phase),
    .step      (step),
    .done      (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      addr_q <= 1'b0;
    end else if (accept) begin
      sh     <= word;
      addr_q <= (ins_op != OP_NOP);
    end else if (step) begin
      sh <= {8'd0, sh[31:8]};
    end
  end

  always_comb begin
    ale      = slot && addr_q;
    we_n     = !(low_phase && addr_q);
    bus_data = ale ? sh[7:0] : 8'h00;
  end
endmodule

// File: rtl/nand_addr_gen_chk.sv
module nand_addr_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ins_valid,
  input logic       ins_ready,
  input logic [7:0] bus_data,
  input logic       ale,
  input logic       we_n,
  input logic       done,
  input logic       slot,
  input logic       addr_q
);
  a_r2_ale_covers_we: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> ale);
  a_r2_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> $stable(bus_data));
  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> !ins_ready);
  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && !addr_q) |-> (we_n && !ale));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ins_ready);
  a_r11_done_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (we_n && !ale && !ins_ready));
endmodule

bind nand_addr_gen nand_addr_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .bus_data  (bus_data),
  .ale       (ale),
  .we_n      (we_n),
  .done      (done),
  .slot      (slot),
  .addr_q    (addr_q)
);

// File: tb/nand_addr_gen_test.sv
module nand_addr_gen_test;
  localparam int BLK_W = 10;
  localparam int PG_W  = 6;
  localparam int COL_W = 12;
  localparam int BC_W  = 8;
  localparam int TW    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ins_valid = 1'b0;
  logic             ins_ready;
  logic [1:0]       ins_op = 2'd0;
  logic             seq_start = 1'b0;
  logic             wrs_adv = 1'b0;
  logic             cfg_wide_page = 1'b0;
  logic [1:0]       cfg_alen = 2'd0;
  logic [BLK_W-1:0] cfg_block = '0;
  logic [PG_W-1:0]  cfg_page = '0;
  logic [COL_W-1:0] cfg_col = '0;
  logic [BC_W-1:0]  cfg_bcount = '0;
  logic [31:0]      mbox = 32'hA1B2C3D4;
  logic [TW-1:0]    cfg_we_lo = '0;
  logic [TW-1:0]    cfg_we_hi = '0;
  logic [7:0]       bus_data;
  logic             ale;
  logic             we_n;
  logic             done;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  nand_addr_gen #(
    .BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W), .BC_W(BC_W), .TW(TW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_op(ins_op), .seq_start(seq_start), .wrs_adv(wrs_adv),
    .cfg_wide_page(cfg_wide_page), .cfg_alen(cfg_alen), .cfg_block(cfg_block),
    .cfg_page(cfg_page), .cfg_col(cfg_col), .cfg_bcount(cfg_bcount),
    .mbox(mbox), .cfg_we_lo(cfg_we_lo), .cfg_we_hi(cfg_we_hi),
    .bus_data(bus_data), .ale(ale), .we_n(we_n), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one instruction and compare every cycle with the expected waveform.
  task automatic run(input logic [1:0] op, input int n, input logic [31:0] w,
                     input string tag);
    int lo_n, hi_n, slot_n, total, bad, c;
    logic [31:0] first_act, first_exp;
    bit isaddr;
    lo_n = int'(cfg_we_lo) + 1;
    hi_n = int'(cfg_we_hi) + 1;
    slot_n = lo_n + hi_n;
    total = n * slot_n + 1;
    isaddr = (op != 2'd0);
    bad = 0;
    first_act = '0;
    first_exp = '0;
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    ins_op = op;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    for (c = 1; c <= total + 1; c++) begin
      int k, r;
      logic e_we_n, e_ale, e_done, e_rdy;
      logic [7:0] e_data;
      k = (c - 1) / slot_n;
      r = (c - 1) % slot_n;
      e_ale  = isaddr && (c < total);
      e_we_n = !(isaddr && (c < total) && (r < lo_n));
      e_done = (c == total);
      e_rdy  = (c == total + 1);
      e_data = e_ale ? w[8*(k%4) +: 8] : 8'h00;
      if (we_n !== e_we_n || ale !== e_ale || done !== e_done ||
          ins_ready !== e_rdy || (e_ale && bus_data !== e_data)) begin
        if (bad == 0) begin
          first_act = {c[7:0], bus_data, 4'd0, ins_ready, done, ale, we_n, 8'd0};
          first_exp = {c[7:0], e_data, 4'd0, e_rdy, e_done, e_ale, e_we_n, 8'd0};
        end
        bad++;
      end
      if (c <= total) @(negedge clk);
    end
    check(bad == 0, tag, first_act, first_exp);
  endtask

  function automatic int page_len(input logic [1:0] a);
    return (a == 2'd0) ? 2 : (a == 2'd1) ? 3 : 4;
  endfunction

  task automatic pulse_seq();
    @(negedge clk);
    seq_start = 1'b1;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic pulse_wrs();
    @(negedge clk);
    wrs_adv = 1'b1;
    @(negedge clk);
    wrs_adv = 1'b0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pv;
    logic [31:0] cv;
    logic [7:0]  ub[4];
    repeat (3) @(negedge clk);
    // R12: reset state
    check(we_n === 1'b1 && ale === 1'b0 && done === 1'b0 && ins_ready === 1'b1,
          "R12 reset outputs", {28'd0, we_n, ale, done, ins_ready}, 32'h9);
    rst_n = 1'b1;
    @(negedge clk);
    check(ins_ready === 1'b1 && we_n === 1'b1, "R12 idle after reset",
          {30'd0, ins_ready, we_n}, 32'h3);

    // R9 / R10 / R11: no-op timing across low/high settings
    for (int lo = 0; lo < 3; lo++)
      for (int hi = 0; hi < 3; hi++) begin
        cfg_we_lo = lo[TW-1:0];
        cfg_we_hi = hi[TW-1:0];
        run(2'd0, 1, 32'd0, "R9 R10 R11 nop slot");
      end

    // R3 / R4 / R6 / R10: column sweep
    for (int wp = 0; wp < 2; wp++)
      for (int bz = 0; bz < 2; bz++)
        for (int lo = 0; lo < 2; lo++) begin
          cfg_wide_page = wp[0];
          cfg_bcount = bz[0] ? 8'd0 : 8'd37;
          cfg_col = 12'hA5C ^ 12'(lo * 12'h111);
          cfg_we_lo = lo[TW-1:0];
          cfg_we_hi = TW'(2 - lo);
          cv = (cfg_bcount == 0) ? 32'd0 : {20'd0, cfg_col};
          run(2'd1, wp + 1, cv, bz[0] ? "R4 column zero on bcount 0" :
                                        "R3 R6 column bytes");
        end

    // R5 / R6 / R2: page sweep
    for (int a = 0; a < 4; a++)
      for (int v = 0; v < 4; v++) begin
        cfg_alen  = a[1:0];
        cfg_block = BLK_W'(10'h2D3 ^ (v * 10'h0F7));
        cfg_page  = PG_W'(6'h15 + v * 7);
        cfg_we_lo = TW'(v % 3);
        cfg_we_hi = TW'((v + a) % 3);
        pv = {16'd0, cfg_block, cfg_page};
        run(2'd2, page_len(cfg_alen), pv, "R5 R6 R2 page bytes");
      end

    // R7: user bytes from mailbox, zeros after the fourth
    cfg_we_lo = 3'd1;
    cfg_we_hi = 3'd0;
    ub[0] = 8'hD4; ub[1] = 8'hC3; ub[2] = 8'hB2; ub[3] = 8'hA1;
    pulse_seq();
    for (int i = 0; i < 6; i++)
      run(2'd3, 1, (i < 4) ? {24'd0, ub[i]} : 32'd0, "R7 user byte sequence");

    // R8: shared pointer with write-status advance, then reset by seq_start
    pulse_seq();
    run(2'd3, 1, {24'd0, ub[0]}, "R8 first after seq_start");
    pulse_wrs();
    run(2'd3, 1, {24'd0, ub[2]}, "R8 skip after wrs_adv");
    pulse_wrs();
    run(2'd3, 1, 32'd0, "R8 R7 exhausted");
    pulse_seq();
    run(2'd3, 1, {24'd0, ub[0]}, "R8 seq_start resets pointer");

    // R1: valid held while busy is accepted only after done
    @(negedge clk);
    cfg_we_lo = 3'd0;
    cfg_we_hi = 3'd0;
    ins_op = 2'd1;
    cfg_wide_page = 1'b1;
    ins_valid = 1'b1;
    @(negedge clk);
    check(ins_ready === 1'b0, "R1 ready low while busy", {31'd0, ins_ready}, 32'd0);
    repeat (4) @(negedge clk);
    check(done === 1'b1, "R1 R11 done after two bytes", {31'd0, done}, 32'd1);
    @(negedge clk);
    check(ins_ready === 1'b1, "R1 ready after done", {31'd0, ins_ready}, 32'd1);
    @(negedge clk);
    check(ins_ready === 1'b0 && ale === 1'b1, "R1 held valid accepted again",
          {30'd0, ins_ready, ale}, 32'd1);
    ins_valid = 1'b0;
    repeat (8) @(negedge clk);
    check(ins_ready === 1'b1, "R1 idle at end", {31'd0, ins_ready}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule